// File: doc/BRIEF.md
# Destination-Address Receive Steering Tagger

This block inspects each received Ethernet frame as it streams past on a 64-bit beat interface and picks the host receive buffer the frame should land in. If the frame carries IPv4 and its destination address equals a programmed address, the block drives a programmed buffer number and an 8-bit match tag. Every other frame goes to buffer 0 with tag 0. The frame beats pass through a single register stage. The steering outputs line up with the delayed beats.

A small finite-state machine follows the header and counts only the beats marked valid. The states are:

- **ST_IDLE**: waiting for start-of-frame.
- **ST_TYPE**: waiting for the beat that holds the ethertype.
- **ST_ADDR**: collecting the destination address across two beats.
- **ST_HOLD**: a decision has been made and the state waits for the frame to end.

The transitions are:

- **start** (ST_IDLE to ST_TYPE): a valid start-of-frame beat arrives that is not also the frame's last beat.
- **ipv4** (ST_TYPE to ST_ADDR): the ethertype matches and steering is enabled.
- **reject** (ST_TYPE to ST_HOLD): the ethertype differs, or steering is disabled.
- **decide** (ST_ADDR to ST_HOLD): the address has been compared.
- **end** (any state to ST_IDLE): the frame finishes with end-of-frame or with an error.

Configuration lives in host-written registers. These are shadowed, and the working copy is loaded at each start-of-frame.

Top module: `ip_steer_tagger`

## Requirements
- R1: Every output beat signal (`out_data`, `out_sof`, `out_eof`, `out_len`, `out_vld`, `out_err`) equals the corresponding input exactly one clock earlier.
- R2: A frame whose valid beat 1 holds 0x0800 in frame bytes 12 (bits 39:32, upper byte) and 13 (bits 47:40), and whose destination address equals the programmed address while enabled, is a hit. The address is bytes 30..33 with byte 30 most significant: beat 3 bits 55:48 and 63:56, then beat 4 bits 7:0 and 15:8. On a hit, `out_buf` and `out_tag` show the programmed buffer and tag together with output beat 4, which is the fifth valid beat.
- R3: A frame that is not IPv4, or that arrives while steering is disabled, is decided as buffer 0 / tag 0 together with valid beat 1. An IPv4 frame whose address differs is decided as buffer 0 / tag 0 at beat 4.
- R4: A frame that ends, by end-of-frame or by the error flag, before its beat-4 decision is decided as buffer 0 / tag 0 together with its final beat. An error flag on beat 4 itself also gives buffer 0 / tag 0.
- R5: Cycles with `in_vld` low inside a frame do not advance the beat position, and no decision is taken on them unless the error flag is raised.
- R6: `out_buf` and `out_tag` change only together with a deciding beat. They therefore hold from the decision through two cycles after end-of-frame, and until the next frame's decision.
- R7: An error flag that arrives after the decision leaves `out_buf` and `out_tag` unchanged.
- R8: Register address 0 holds the match address. Address 1 holds the buffer number in bits BUF_W-1:0, the tag in bits 8+TAG_W-1:8 and the enable in bit 31. Addresses 2 and 3 are ignored. A write changes steering only from the next start-of-frame on, and a frame in flight keeps the settings latched at its own start.
- R9: `hit_count` rises by exactly one for each hit decision and wraps modulo 2^CNT_W.
- R10: After reset, all output beat signals, `out_buf`, `out_tag` and `hit_count` are 0, and steering is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| in_data | input | 64 | Received beat, byte 0 in bits 7:0 |
| in_sof | input | 1 | First beat of frame |
| in_eof | input | 1 | Last beat of frame |
| in_len | input | 3 | Valid bytes in last beat |
| in_vld | input | 1 | Beat valid |
| in_err | input | 1 | Abnormal frame termination |
| out_data | output | 64 | Delayed beat |
| out_sof | output | 1 | Delayed first-beat flag |
| out_eof | output | 1 | Delayed last-beat flag |
| out_len | output | 3 | Delayed length |
| out_vld | output | 1 | Delayed valid |
| out_err | output | 1 | Delayed error flag |
| out_buf | output | 6 | Selected host buffer |
| out_tag | output | 8 | Match tag |
| hit_count | output | CNT_W | Number of hits, wrapping |

## Verification
The bench builds the block with a 4-bit hit counter, so that the wrap of R9 is reached after sixteen hits. All other parameters keep their defaults. Using the default beat width keeps the header byte positions exactly as stated. The bench sweeps frame lengths from one to eight beats against three kinds of header, with varying patterns of invalid gap cycles. It also places the error flag on every beat from 0 to 6, which brings every early-termination path and the post-decision hold within reach.

// File: rtl/steer_pkg.sv
package steer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TYPE,
        ST_ADDR,
        ST_HOLD
    } steer_state_e;

    localparam logic [15:0] IPV4_ETYPE = 16'h0800;
    localparam int TYPE_BEAT  = 1;
    localparam int HI_BEAT    = 3;
    localparam int ADDR_BEAT  = 4;
    localparam int BEAT_CW    = $clog2(ADDR_BEAT + 2);
    localparam int TAG_LSB    = 8;
    localparam int EN_BIT     = 31;
endpackage

// File: rtl/steer_cfg.sv
module steer_cfg
    import steer_pkg::*;
#(
    parameter int BUF_W = 6,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       waddr,
    input  logic [31:0]      wdata,
    input  logic             frame_start,
    output logic [31:0]      act_ip,
    output logic [BUF_W-1:0] act_buf,
    output logic [TAG_W-1:0] act_tag,
    output logic             act_en
);
    logic [31:0] sh_ip;
    logic [31:0] sh_ctl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_ip  <= '0;
            sh_ctl <= '0;
        end else if (we) begin
            if (waddr == 2'd0) sh_ip  <= wdata;
            if (waddr == 2'd1) sh_ctl <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ip  <= '0;
            act_buf <= '0;
            act_tag <= '0;
            act_en  <= 1'b0;
        end else if (frame_start) begin
            act_ip  <= sh_ip;
            act_buf <= sh_ctl[BUF_W-1:0];
            act_tag <= sh_ctl[TAG_LSB +: TAG_W];
            act_en  <= sh_ctl[EN_BIT];
        end
    end

    logic unused_ctl;
    assign unused_ctl = ^sh_ctl;
endmodule

// File: rtl/steer_pipe.sv
module steer_pipe #(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] i_data,
    input  logic              i_sof,
    input  logic              i_eof,
    input  logic [LEN_W-1:0]  i_len,
    input  logic              i_vld,
    input  logic              i_err,
    output logic [DATA_W-1:0] o_data,
    output logic              o_sof,
    output logic              o_eof,
    output logic [LEN_W-1:0]  o_len,
    output logic              o_vld,
    output logic              o_err
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_data <= '0;
            o_sof  <= 1'b0;
            o_eof  <= 1'b0;
            o_len  <= '0;
            o_vld  <= 1'b0;
            o_err  <= 1'b0;
        end else begin
            o_data <= i_data;
            o_sof  <= i_sof;
            o_eof  <= i_eof;
            o_len  <= i_len;
            o_vld  <= i_vld;
            o_err  <= i_err;
        end
    end
endmodule

// File: rtl/steer_fsm.sv
module steer_fsm
    import steer_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_err,
    input  logic [DATA_W-1:0] in_data,
    input  logic [31:0]       act_ip,
    input  logic              act_en,
    output logic              dec_stb,
    output logic              dec_hit,
    output logic              st_hold
);
    steer_state_e       state_q, state_d;
    logic [BEAT_CW-1:0] idx_q, idx_d;
    logic [15:0]        iphi_q, iphi_d;

    logic        fin;
    logic [15:0] etype;
    logic [31:0] ip_full;

    assign fin     = (in_vld && in_eof) || in_err;
    assign etype   = {in_data[39:32], in_data[47:40]};
    assign ip_full = {iphi_q, in_data[7:0], in_data[15:8]};
    assign st_hold = (state_q == ST_HOLD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            iphi_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            iphi_q  <= iphi_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        iphi_d  = iphi_q;
        dec_stb = 1'b0;
        dec_hit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_vld && in_sof) begin
                    idx_d = BEAT_CW'(TYPE_BEAT);
                    if (fin) dec_stb = 1'b1;
                    else     state_d = ST_TYPE;
                end
            end
            ST_TYPE: begin
                if (in_err) begin
                    dec_stb = 1'b1;
                    state_d = ST_IDLE;
                end else if (in_vld) begin
                    idx_d = idx_q + 1'b1;
                    if (in_eof) begin
                        dec_stb = 1'b1;
                        state_d = ST_IDLE;
                    end else if (etype == IPV4_ETYPE && act_en) begin
                        state_d = ST_ADDR;
                    end else begin
                        dec_stb = 1'b1;
                        state_d = ST_HOLD;
                    end
                end
            end
            ST_ADDR: begin
                if (in_err) begin
                    dec_stb = 1'b1;
                    state_d = ST_IDLE;
                end else if (in_vld) begin
                    idx_d = idx_q + 1'b1;
                    if (idx_q == BEAT_CW'(HI_BEAT))
                        iphi_d = {in_data[55:48], in_data[63:56]};
                    if (idx_q == BEAT_CW'(ADDR_BEAT)) begin
                        dec_stb = 1'b1;
                        dec_hit = (ip_full == act_ip);
                        state_d = in_eof ? ST_IDLE : ST_HOLD;
                    end else if (in_eof) begin
                        dec_stb = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (fin) state_d = ST_IDLE;
            end
        endcase
    end

    logic unused_data;
    assign unused_data = ^in_data;
endmodule

// File: rtl/ip_steer_tagger.sv
module ip_steer_tagger
    import steer_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 3,
    parameter int BUF_W  = 6,
    parameter int TAG_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_vld,
    input  logic              in_err,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_vld,
    output logic              out_err,
    output logic [BUF_W-1:0]  out_buf,
    output logic [TAG_W-1:0]  out_tag,
    output logic [CNT_W-1:0]  hit_count
);
    logic [31:0]      act_ip;
    logic [BUF_W-1:0] act_buf;
    logic [TAG_W-1:0] act_tag;
    logic             act_en;
    logic             dec_stb;
    logic             dec_hit;
    logic             st_hold;

    steer_cfg #(.BUF_W(BUF_W), .TAG_W(TAG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
        .wdata(cfg_wdata), .frame_start(in_vld && in_sof),
        .act_ip(act_ip), .act_buf(act_buf), .act_tag(act_tag), .act_en(act_en)
    );

    steer_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sof(in_sof),
        .in_eof(in_eof), .in_err(in_err), .in_data(in_data),
        .act_ip(act_ip), .act_en(act_en),
        .dec_stb(dec_stb), .dec_hit(dec_hit), .st_hold(st_hold)
    );

    steer_pipe #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .i_data(in_data), .i_sof(in_sof), .i_eof(in_eof),
        .i_len(in_len), .i_vld(in_vld), .i_err(in_err),
        .o_data(out_data), .o_sof(out_sof), .o_eof(out_eof),
        .o_len(out_len), .o_vld(out_vld), .o_err(out_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_buf   <= '0;
            out_tag   <= '0;
            hit_count <= '0;
        end else if (dec_stb) begin
            if (dec_hit) begin
                out_buf   <= act_buf;
                out_tag   <= act_tag;
                hit_count <= hit_count + 1'b1;
            end else begin
                out_buf   <= '0;
                out_tag   <= '0;
            end
        end
    end
endmodule

// File: rtl/steer_chk.sv
module steer_chk #(
    parameter int BUF_W = 6,
    parameter int TAG_W = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic             in_eof,
    input logic             in_err,
    input logic             out_vld,
    input logic             out_eof,
    input logic [BUF_W-1:0] out_buf,
    input logic [TAG_W-1:0] out_tag,
    input logic [CNT_W-1:0] hit_count,
    input logic             dec_stb,
    input logic             st_hold
);
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_vld == $past(in_vld) && out_eof == $past(in_eof))); // R1

    AST_DECIDE_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stb |-> (in_vld || in_err)); // R5

    AST_STEER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(dec_stb)) |-> ($stable(out_buf) && $stable(out_tag))); // R6

    AST_LATE_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_hold && in_err) |=> ($stable(out_buf) && $stable(out_tag))); // R7

    AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && hit_count != $past(hit_count)) |->
            (hit_count == CNT_W'($past(hit_count) + 1'b1) && $past(dec_stb))); // R9
endmodule

bind ip_steer_tagger steer_chk #(.BUF_W(BUF_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_eof(in_eof), .in_err(in_err),
    .out_vld(out_vld), .out_eof(out_eof), .out_buf(out_buf), .out_tag(out_tag),
    .hit_count(hit_count), .dec_stb(dec_stb), .st_hold(st_hold)
);

// File: tb/ip_steer_tagger_bench.sv
module ip_steer_tagger_bench;
    localparam int CW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [63:0] in_data = '0;
    logic        in_sof = 1'b0, in_eof = 1'b0, in_vld = 1'b0, in_err = 1'b0;
    logic [2:0]  in_len = '0;
    logic [63:0] out_data;
    logic        out_sof, out_eof, out_vld, out_err;
    logic [2:0]  out_len;
    logic [5:0]  out_buf;
    logic [7:0]  out_tag;
    logic [CW-1:0] hit_count;

    always #10 clk = ~clk;

    ip_steer_tagger #(.CNT_W(CW)) u_ip_steer_tagger (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_data(in_data), .in_sof(in_sof),
        .in_eof(in_eof), .in_len(in_len), .in_vld(in_vld), .in_err(in_err),
        .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
        .out_len(out_len), .out_vld(out_vld), .out_err(out_err),
        .out_buf(out_buf), .out_tag(out_tag), .hit_count(hit_count)
    );

    int checks = 0;
    int failures = 0;

    // model configuration and state
    logic [31:0] m_ip = '0;
    logic [5:0]  m_buf = '0;
    logic [7:0]  m_tag = '0;
    logic        m_en = 1'b0;
    int          m_hits = 0;
    logic [5:0]  cur_buf = '0;
    logic [7:0]  cur_tag = '0;

    // previous driven beat
    logic        p_v = 0, p_s = 0, p_e = 0, p_er = 0;
    logic [63:0] p_d = '0;
    logic [2:0]  p_l = '0;
    logic [5:0]  p_xb = '0;
    logic [7:0]  p_xt = '0;
    string       p_lab = "R10";

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic s, input logic e, input logic er,
                       input logic [63:0] d, input logic [2:0] l,
                       input logic [5:0] xb, input logic [7:0] xt, input string lab);
        @(posedge clk); #1;
        in_vld = v; in_sof = s; in_eof = e; in_err = er; in_data = d; in_len = l;
        @(negedge clk);
        chk("R1 vld", 64'(out_vld), 64'(p_v));
        chk("R1 sof", 64'(out_sof), 64'(p_s));
        chk("R1 eof", 64'(out_eof), 64'(p_e));
        chk("R1 err", 64'(out_err), 64'(p_er));
        chk("R1 len", 64'(out_len), 64'(p_l));
        chk("R1 data", out_data, p_d);
        chk({p_lab, " buf"}, 64'(out_buf), 64'(p_xb));
        chk({p_lab, " tag"}, 64'(out_tag), 64'(p_xt));
        p_v = v; p_s = s; p_e = e; p_er = er; p_d = d; p_l = l;
        p_xb = xb; p_xt = xt; p_lab = lab;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    function automatic logic [7:0] fbyte(input int i, input bit ipv4, input logic [31:0] ip);
        case (i)
            12: return ipv4 ? 8'h08 : 8'h86;
            13: return ipv4 ? 8'h00 : 8'hDD;
            30: return ip[31:24];
            31: return ip[23:16];
            32: return ip[15:8];
            33: return ip[7:0];
            default: return 8'(i * 7 + 3);
        endcase
    endfunction

    // err_at < 0: no error; mid: write new control at beat 2
    task automatic frame(input bit ipv4, input logic [31:0] ip, input int nb,
                         input int gapmask, input int err_at, input bit mid,
                         input logic [31:0] mid_ctl, input string base);
        int fe, dpos;
        bit hit;
        logic [5:0] eb;
        logic [7:0] et;
        string lab;
        fe = (err_at >= 0) ? err_at : nb - 1;
        hit = 1'b0;
        if (!(ipv4 && m_en)) dpos = (fe < 1) ? fe : 1;
        else if (fe < 4 || (fe == 4 && err_at == 4)) dpos = fe;
        else begin dpos = 4; hit = (ip == m_ip); end
        eb = hit ? m_buf : 6'd0;
        et = hit ? m_tag : 8'd0;
        lab = (gapmask != 0) ? {base, "/R5"} : base;
        for (int k = 0; k <= fe; k++) begin
            logic [63:0] d;
            for (int b = 0; b < 8; b++) d[b*8 +: 8] = fbyte(k * 8 + b, ipv4, ip);
            if (mid && k == 2) begin
                cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = mid_ctl;
            end
            cyc(1'b1, k == 0, (err_at < 0) && (k == nb - 1), k == err_at, d,
                (k == nb - 1) ? 3'(nb) : 3'd0,
                (k >= dpos) ? eb : cur_buf, (k >= dpos) ? et : cur_tag,
                (k >= dpos) ? lab : "R6");
            if (mid && k == 2) cfg_we = 1'b0;
            if (((gapmask >> k) & 1) == 1 && k < fe)
                cyc(1'b0, 1'b0, 1'b0, 1'b0, 64'd0, 3'd0,
                    (k >= dpos) ? eb : cur_buf, (k >= dpos) ? et : cur_tag,
                    (k >= dpos) ? lab : "R6");
        end
        cur_buf = eb; cur_tag = et;
        if (hit) m_hits++;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 64'd0, 3'd0, eb, et, "R6");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 64'd0, 3'd0, eb, et, "R6");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 64'd0, 3'd0, eb, et, "R6");
        chk("R9 hit_count", 64'(hit_count), 64'(m_hits % (1 << CW)));
        if (mid) begin
            m_buf = mid_ctl[5:0]; m_tag = mid_ctl[15:8]; m_en = mid_ctl[31];
        end
    endtask

    task automatic set_cfg(input logic [31:0] ip, input logic [5:0] b,
                           input logic [7:0] t, input bit en);
        wr(2'd0, ip);
        wr(2'd1, {en, 15'd0, t, 2'd0, b});
        m_ip = ip; m_buf = b; m_tag = t; m_en = en;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] mip;
        mip = 32'hC0A8_0105;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R10 out_vld", 64'(out_vld), 64'd0);
        chk("R10 out_buf", 64'(out_buf), 64'd0);
        chk("R10 out_tag", 64'(out_tag), 64'd0);
        chk("R10 hit_count", 64'(hit_count), 64'd0);
        // steering disabled after reset: matching frame still misses
        wr(2'd0, mip);
        m_ip = mip;
        frame(1'b1, mip, 6, 0, -1, 1'b0, 32'd0, "R10");

        set_cfg(mip, 6'd37, 8'hA5, 1'b1);
        // sweep lengths, header kinds and gap patterns
        for (int nb = 1; nb <= 8; nb++) begin
            for (int kind = 0; kind < 3; kind++) begin
                string b;
                logic [31:0] ip;
                ip = (kind == 2) ? (mip ^ (32'h1 << (nb * 3))) : mip;
                b = (kind == 1 && nb >= 5) ? "R2" : ((nb < 5 && kind != 0) ? "R4" : "R3");
                frame(kind != 0, ip, nb, (nb * 5 + kind) & 8'h2A, -1, 1'b0, 32'd0, b);
            end
        end
        // error placed on each beat
        for (int ea = 0; ea <= 6; ea++)
            frame(1'b1, mip, 10, 0, ea, 1'b0, 32'd0, (ea > 4) ? "R7" : "R4");
        // explicit gap frame, valid beats only counted
        frame(1'b1, mip, 7, 8'h1F, -1, 1'b0, 32'd0, "R5");
        // ignored address and a write landing mid-frame
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'h0000_0000);
        frame(1'b1, mip, 6, 0, -1, 1'b1, {1'b1, 15'd0, 8'h3C, 2'd0, 6'd12}, "R8");
        frame(1'b1, mip, 6, 0, -1, 1'b0, 32'd0, "R8");
        // disable via register, then re-enable with a different buffer 0 tag
        set_cfg(mip, 6'd5, 8'h11, 1'b0);
        frame(1'b1, mip, 6, 0, -1, 1'b0, 32'd0, "R3");
        set_cfg(32'h0A00_00FE, 6'd0, 8'h77, 1'b1);
        frame(1'b1, 32'h0A00_00FE, 5, 0, -1, 1'b0, 32'd0, "R2");
        // counter wrap
        set_cfg(mip, 6'd63, 8'hFF, 1'b1);
        for (int i = 0; i < 18; i++)
            frame(1'b1, mip, 6, i & 3, -1, 1'b0, 32'd0, "R9");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule